// File: doc/BRIEF.md
# IPv4 Transmit Header Encapsulator

This block turns a host payload into a complete IPv4 datagram for an endpoint device that does no routing and no fragmentation. The host first writes payload bytes into a transmit buffer inside the block through a plain write port, at addresses 0 up to length minus 1. It then sets the addressing and service fields and the payload byte count, and pulses `start`. The block captures those settings and builds a 20-byte header with no options. The header carries the total length, a per-datagram identification number, the don't-fragment flag and a computed header checksum. The block then streams header and payload, one byte per clock, to the MAC side.

The MAC-side output is a valid/ready byte stream. A byte moves on a rising edge where `out_valid` and `out_ready` are both high. While `out_valid` is high and `out_ready` is low, the block holds `out_data` and `out_last` unchanged and keeps `out_valid` high. `out_ready` may toggle freely on any cycle. Each step of the pipeline selects one byte from the header or the buffer and registers it into the output stage. A payload count above 1480 bytes is refused, and nothing is sent for it.

Top module: `ipv4_tx_encap`

## Requirements
- R1: After reset, `busy`, `out_valid` and `len_err` are 0.
- R2: The datagram is sent in this byte order:
  - byte 0 is 0x45.
  - byte 1 is the type of service.
  - bytes 2-3 are the total length, high byte first.
  - bytes 4-5 are the identification, high byte first.
  - bytes 6-7 are 0x40 0x00, which means don't-fragment with fragment offset 0.
  - byte 8 is the time to live.
  - byte 9 is the protocol.
  - bytes 10-11 are the checksum, high byte first.
  - bytes 12-15 are the source address, most significant byte first.
  - bytes 16-19 are the destination address, most significant byte first.
- R3: The checksum is the ones'-complement of the ones'-complement sum of the ten 16-bit header words, with the checksum word taken as zero. The ones'-complement sum of all ten words as sent is therefore 0xFFFF.
- R4: The total length equals 20 plus `pay_len`. Header byte 19 is followed by buffer bytes 0 to `pay_len`-1 in address order.
- R5: The identification is 0 for the first datagram sent after reset. It increases by 1 for each datagram that is accepted.
- R6: A `start` with `pay_len` greater than 1480 sends nothing. It leaves `busy` low, sets `len_err`, and uses up no identification value. `len_err` stays high until the next accepted `start`, which clears it.
- R7: While `out_valid` is high and `out_ready` is low, `out_valid`, `out_data` and `out_last` hold their values on the next cycle.
- R8: `out_last` is high on the final byte of the datagram and on no other byte.
- R9: `busy` rises on the edge that accepts `start`. It falls on the edge where the last byte is taken. A `start` pulse while `busy` is high has no effect on the datagram being sent.
- R10: The configuration fields and `pay_len` are captured when `start` is accepted. Changes to them during a transmission have no effect on that datagram.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Buffer write strobe |
| wr_addr | input | 11 | Buffer write byte address |
| wr_data | input | 8 | Buffer write byte |
| cfg_src | input | 32 | Source address |
| cfg_dst | input | 32 | Destination address |
| cfg_proto | input | 8 | Protocol number |
| cfg_tos | input | 8 | Type of service |
| cfg_ttl | input | 8 | Time to live |
| pay_len | input | 12 | Payload byte count |
| start | input | 1 | Transmit request strobe |
| busy | output | 1 | Datagram in progress |
| len_err | output | 1 | Last request was refused as too long |
| out_valid | output | 1 | Output byte valid |
| out_ready | input | 1 | Sink accepts the byte |
| out_data | output | 8 | Output byte |
| out_last | output | 1 | Final byte of the datagram |

## Verification
The bench sends datagrams with four sink patterns:
- a sink that is always ready, which shows the one-byte-per-clock rate;
- a sink that is ready on alternate cycles, which finds off-by-one errors in the byte index;
- a sink that is ready at random, which tests the handshake hold under mixed stalls;
- a sink with runs of stalls, which tests that a byte is held over several cycles.

The payload lengths are 0, small, medium and the 1480-byte maximum. These lengths separate the end of the header, the last flag and the total-length field. Address and field values that force carries in the checksum fold separate a correct fold from a single fold. One transfer changes the configuration and pulses `start` in the middle of the datagram, to show that the captured fields are kept.

// File: rtl/ipv4_tx_pkg.sv
package ipv4_tx_pkg;
  localparam int HDR_BYTES = 20;
  localparam logic [7:0] VER_IHL = 8'h45;
  localparam logic [7:0] FLAG_DF = 8'h40;

  typedef struct packed {
    logic [7:0]  tos;
    logic [7:0]  ttl;
    logic [7:0]  proto;
    logic [31:0] src;
    logic [31:0] dst;
    logic [15:0] tot_len;
    logic [15:0] ident;
  } hdr_fields_t;

  function automatic logic [15:0] fold_sum(input logic [19:0] s);
    logic [16:0] t;
    t = {1'b0, s[15:0]} + {13'd0, s[19:16]};
    t = {1'b0, t[15:0]} + {16'd0, t[16]};
    return t[15:0];
  endfunction
endpackage

// File: rtl/ipv4_tx_buf.sv
module ipv4_tx_buf #(
  parameter int DEPTH = 2048,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [7:0]    wr_data,
  input  logic [AW-1:0] rd_addr,
  output logic [7:0]    rd_data
);
  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_data;
  end

  assign rd_data = mem[rd_addr];
endmodule

// File: rtl/ipv4_hdr_gen.sv
module ipv4_hdr_gen
  import ipv4_tx_pkg::*;
(
  input  hdr_fields_t f,
  input  logic [4:0]  sel,
  output logic [7:0]  hdr_byte
);
  localparam int NWORDS = 9;
  logic [15:0] words [NWORDS];
  logic [19:0] acc;
  logic [15:0] csum;

  always_comb begin
    words[0] = {VER_IHL, f.tos};
    words[1] = f.tot_len;
    words[2] = f.ident;
    words[3] = {FLAG_DF, 8'h00};
    words[4] = {f.ttl, f.proto};
    words[5] = f.src[31:16];
    words[6] = f.src[15:0];
    words[7] = f.dst[31:16];
    words[8] = f.dst[15:0];
    acc = '0;
    for (int i = 0; i < NWORDS; i++) acc = acc + {4'd0, words[i]};
    csum = ~fold_sum(acc);
  end

  always_comb begin
    case (sel)
      5'd0:    hdr_byte = VER_IHL;
      5'd1:    hdr_byte = f.tos;
      5'd2:    hdr_byte = f.tot_len[15:8];
      5'd3:    hdr_byte = f.tot_len[7:0];
      5'd4:    hdr_byte = f.ident[15:8];
      5'd5:    hdr_byte = f.ident[7:0];
      5'd6:    hdr_byte = FLAG_DF;
      5'd8:    hdr_byte = f.ttl;
      5'd9:    hdr_byte = f.proto;
      5'd10:   hdr_byte = csum[15:8];
      5'd11:   hdr_byte = csum[7:0];
      5'd12:   hdr_byte = f.src[31:24];
      5'd13:   hdr_byte = f.src[23:16];
      5'd14:   hdr_byte = f.src[15:8];
      5'd15:   hdr_byte = f.src[7:0];
      5'd16:   hdr_byte = f.dst[31:24];
      5'd17:   hdr_byte = f.dst[23:16];
      5'd18:   hdr_byte = f.dst[15:8];
      5'd19:   hdr_byte = f.dst[7:0];
      default: hdr_byte = 8'h00;
    endcase
  end
endmodule

// File: rtl/ipv4_tx_seq.sv
module ipv4_tx_seq
  import ipv4_tx_pkg::*;
#(
  parameter int DEPTH   = 2048,
  parameter int PAY_MAX = 1480,
  localparam int AW = $clog2(DEPTH),
  localparam int LW = AW + 1,
  localparam int IW = LW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [31:0]   cfg_src,
  input  logic [31:0]   cfg_dst,
  input  logic [7:0]    cfg_proto,
  input  logic [7:0]    cfg_tos,
  input  logic [7:0]    cfg_ttl,
  input  logic [LW-1:0] pay_len,
  input  logic          start,
  input  logic [7:0]    hdr_byte,
  input  logic [7:0]    buf_byte,
  output hdr_fields_t   fields,
  output logic [4:0]    hdr_sel,
  output logic [AW-1:0] rd_addr,
  output logic          busy,
  output logic          len_err,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [7:0]    out_data,
  output logic          out_last
);
  logic [IW-1:0] idx;
  logic [IW-1:0] total;
  logic [15:0]   ident_ctr;
  logic          in_hdr;
  logic          load;
  logic          too_long;

  assign too_long = pay_len > LW'(PAY_MAX);
  assign in_hdr   = idx < IW'(HDR_BYTES);
  assign hdr_sel  = idx[4:0];
  assign rd_addr  = AW'(idx - IW'(HDR_BYTES));
  assign load     = busy && (!out_valid || out_ready) && (idx < total);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy      <= 1'b0;
      len_err   <= 1'b0;
      out_valid <= 1'b0;
      out_data  <= '0;
      out_last  <= 1'b0;
      idx       <= '0;
      total     <= '0;
      ident_ctr <= '0;
      fields    <= '0;
    end else if (start && !busy) begin
      if (too_long) begin
        len_err <= 1'b1;
      end else begin
        len_err        <= 1'b0;
        busy           <= 1'b1;
        idx            <= '0;
        total          <= IW'(pay_len) + IW'(HDR_BYTES);
        fields.tos     <= cfg_tos;
        fields.ttl     <= cfg_ttl;
        fields.proto   <= cfg_proto;
        fields.src     <= cfg_src;
        fields.dst     <= cfg_dst;
        fields.tot_len <= 16'(pay_len) + 16'(HDR_BYTES);
        fields.ident   <= ident_ctr;
        ident_ctr      <= ident_ctr + 16'd1;
      end
    end else if (load) begin
      out_valid <= 1'b1;
      out_data  <= in_hdr ? hdr_byte : buf_byte;
      out_last  <= (idx == total - IW'(1));
      idx       <= idx + IW'(1);
    end else if (out_valid && out_ready) begin
      out_valid <= 1'b0;
      if (out_last) busy <= 1'b0;
    end
  end

  a_r7_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_last));
  a_r9_valid_in_busy: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> busy);
  a_r9_busy_holds: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !(out_valid && out_ready && out_last) |=> busy);
  a_r8_last_ends: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_ready && out_last |=> !busy && !out_valid);
  a_r6_reject: assert property (@(posedge clk) disable iff (!rst_n)
    start && !busy && too_long |=> !busy && len_err && !out_valid);
endmodule

// File: rtl/ipv4_tx_encap.sv
module ipv4_tx_encap
  import ipv4_tx_pkg::*;
#(
  parameter int DEPTH   = 2048,
  parameter int PAY_MAX = 1480,
  localparam int AW = $clog2(DEPTH),
  localparam int LW = AW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [7:0]    wr_data,
  input  logic [31:0]   cfg_src,
  input  logic [31:0]   cfg_dst,
  input  logic [7:0]    cfg_proto,
  input  logic [7:0]    cfg_tos,
  input  logic [7:0]    cfg_ttl,
  input  logic [LW-1:0] pay_len,
  input  logic          start,
  output logic          busy,
  output logic          len_err,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [7:0]    out_data,
  output logic          out_last
);
  hdr_fields_t   fields;
  logic [4:0]    hdr_sel;
  logic [7:0]    hdr_byte;
  logic [AW-1:0] rd_addr;
  logic [7:0]    buf_byte;

  ipv4_tx_buf #(.DEPTH(DEPTH)) u_buf (
    .clk(clk), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(buf_byte)
  );

  ipv4_hdr_gen u_hdr (.f(fields), .sel(hdr_sel), .hdr_byte(hdr_byte));

  ipv4_tx_seq #(.DEPTH(DEPTH), .PAY_MAX(PAY_MAX)) u_seq (
    .clk(clk), .rst_n(rst_n),
    .cfg_src(cfg_src), .cfg_dst(cfg_dst), .cfg_proto(cfg_proto),
    .cfg_tos(cfg_tos), .cfg_ttl(cfg_ttl), .pay_len(pay_len),
    .start(start), .hdr_byte(hdr_byte), .buf_byte(buf_byte),
    .fields(fields), .hdr_sel(hdr_sel), .rd_addr(rd_addr),
    .busy(busy), .len_err(len_err),
    .out_valid(out_valid), .out_ready(out_ready),
    .out_data(out_data), .out_last(out_last)
  );
endmodule

// File: tb/test_ipv4_tx_encap.sv
`timescale 1ns/1ps
module test_ipv4_tx_encap;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [10:0] wr_addr = '0;
  logic [7:0]  wr_data = '0;
  logic [31:0] cfg_src = '0, cfg_dst = '0;
  logic [7:0]  cfg_proto = '0, cfg_tos = '0, cfg_ttl = '0;
  logic [11:0] pay_len = '0;
  logic        start = 1'b0;
  logic        busy, len_err, out_valid, out_data_last, out_last;
  logic        out_ready = 1'b0;
  logic [7:0]  out_data;

  int errors = 0;
  int checks = 0;
  int exp_id = 0;
  byte unsigned model_mem [2048];
  byte unsigned exp_q [$];
  byte unsigned got_hdr [20];

  always #5 clk = ~clk;

  ipv4_tx_encap i_ipv4_tx_encap (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .cfg_src(cfg_src), .cfg_dst(cfg_dst), .cfg_proto(cfg_proto), .cfg_tos(cfg_tos),
    .cfg_ttl(cfg_ttl), .pay_len(pay_len), .start(start), .busy(busy),
    .len_err(len_err), .out_valid(out_valid), .out_ready(out_ready),
    .out_data(out_data), .out_last(out_last)
  );
  assign out_data_last = out_last;

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic write_payload(input int n, input int seed);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      wr_en = 1'b1;
      wr_addr = 11'(i);
      wr_data = 8'((i * seed + 7) ^ (i >> 3));
      model_mem[i] = wr_data;
    end
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  function automatic int ref_csum(input int len, input int id);
    int s;
    s = 32'h4500 + cfg_tos + (len + 20) + id + 32'h4000 + {cfg_ttl, cfg_proto}
      + cfg_src[31:16] + cfg_src[15:0] + cfg_dst[31:16] + cfg_dst[15:0];
    while (s > 32'hFFFF) s = (s & 32'hFFFF) + (s >> 16);
    return (~s) & 32'hFFFF;
  endfunction

  task automatic build_expect(input int len);
    int ck, tl;
    tl = len + 20;
    ck = ref_csum(len, exp_id);
    exp_q.delete();
    exp_q.push_back(8'h45); exp_q.push_back(cfg_tos);
    exp_q.push_back(8'(tl >> 8)); exp_q.push_back(8'(tl));
    exp_q.push_back(8'(exp_id >> 8)); exp_q.push_back(8'(exp_id));
    exp_q.push_back(8'h40); exp_q.push_back(8'h00);
    exp_q.push_back(cfg_ttl); exp_q.push_back(cfg_proto);
    exp_q.push_back(8'(ck >> 8)); exp_q.push_back(8'(ck));
    for (int b = 3; b >= 0; b--) exp_q.push_back(8'(cfg_src >> (8 * b)));
    for (int b = 3; b >= 0; b--) exp_q.push_back(8'(cfg_dst >> (8 * b)));
    for (int i = 0; i < len; i++) exp_q.push_back(model_mem[i]);
  endtask

  function automatic bit ready_for(input int mode, input int cyc);
    case (mode)
      0: return 1'b1;
      1: return (cyc % 2) == 0;
      2: return ($urandom % 4) != 0;
      default: return (cyc % 7) >= 3;
    endcase
  endfunction

  // Sends one datagram and compares each accepted byte against the model.
  task automatic send(input int len, input int mode, input bit disturb);
    int total, got, cyc, s;
    bit prev_stall;
    logic [7:0] prev_data;
    logic prev_last;
    total = len + 20;
    build_expect(len);
    @(negedge clk);
    pay_len = 12'(len);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check(busy === 1'b1, "R9 busy after start", busy, 1);
    check(len_err === 1'b0, "R6 len_err cleared", len_err, 0);
    exp_id++;
    got = 0; cyc = 0; prev_stall = 0; prev_data = '0; prev_last = 0;
    while (got < total && cyc < 20000) begin
      @(negedge clk);
      cyc++;
      out_ready = ready_for(mode, cyc);
      start = disturb && (cyc == 6);
      if (disturb && cyc == 3) begin
        cfg_src = ~cfg_src; cfg_tos = cfg_tos + 8'd1; pay_len = 12'd3;
      end
      #1;
      check(busy === 1'b1, "R9 busy during datagram", busy, 1);
      if (prev_stall)
        check(out_valid === 1'b1 && out_data === prev_data && out_last === prev_last,
              "R7 held under stall", {out_valid, out_data}, {1'b1, prev_data});
      if (out_valid && out_ready) begin
        check(out_data === exp_q[got], (got < 20) ? "R2 header byte" : "R4 payload byte",
              out_data, exp_q[got]);
        check(out_last === (got == total - 1), "R8 last flag", out_last, got == total - 1);
        if (got < 20) got_hdr[got] = out_data;
        got++;
      end
      prev_stall = out_valid && !out_ready;
      prev_data = out_data;
      prev_last = out_last;
    end
    start = 1'b0;
    check(got == total, "R4 byte count", got, total);
    @(negedge clk);
    check(busy === 1'b0 && out_valid === 1'b0, "R9 idle after last", {busy, out_valid}, 0);
    s = 0;
    for (int w = 0; w < 10; w++) s += {got_hdr[2 * w], got_hdr[2 * w + 1]};
    while (s > 32'hFFFF) s = (s & 32'hFFFF) + (s >> 16);
    check(s == 32'hFFFF, "R3 header sums to FFFF", s, 32'hFFFF);
    out_ready = 1'b0;
    repeat (3) begin
      @(negedge clk);
      check(busy === 1'b0 && out_valid === 1'b0, "R9 mid-run start ignored", {busy, out_valid}, 0);
    end
  endtask

  initial begin
    #1_000_000;
    errors++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(busy === 1'b0 && out_valid === 1'b0 && len_err === 1'b0, "R1 reset state",
          {busy, out_valid, len_err}, 0);
    rst_n = 1'b1;

    cfg_src = 32'hC0A8_0101; cfg_dst = 32'hC0A8_01FE;
    cfg_proto = 8'h11; cfg_tos = 8'h00; cfg_ttl = 8'h40;
    write_payload(46, 3);
    send(46, 0, 0);                         // R2 R3 R4 R5 basic, id 0

    cfg_src = 32'hFFFF_FFFF; cfg_dst = 32'hFFFF_FFFF;
    cfg_tos = 8'hB8; cfg_ttl = 8'hFF; cfg_proto = 8'hFF;
    send(0, 1, 0);                          // header only, carry-heavy checksum, id 1

    cfg_src = 32'h0A00_0001; cfg_dst = 32'h0A00_0002; cfg_tos = 8'h10; cfg_ttl = 8'h01;
    write_payload(300, 5);
    send(300, 2, 1);                        // R10 config change + R9 mid-run start

    @(negedge clk);
    pay_len = 12'd1481; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check(busy === 1'b0 && len_err === 1'b1, "R6 oversize refused", {busy, len_err}, 1);
    repeat (4) begin
      @(negedge clk);
      check(out_valid === 1'b0 && len_err === 1'b1, "R6 nothing sent, flag held",
            {out_valid, len_err}, 1);
    end

    cfg_src = 32'h8000_0001; cfg_dst = 32'h7FFF_FFFE; cfg_tos = 8'h20; cfg_ttl = 8'h80; cfg_proto = 8'h06;
    write_payload(1480, 7);
    send(1480, 3, 0);                       // maximum length, id 3 shows R5 skipped the refused one

    send(5, 0, 0);                          // R5 id 4
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule